// File: doc/BRIEF.md
# Halt Stall and Release Controller

This block governs a halt instruction in a five-stage in-order pipeline. It watches the word sitting in the decode stage. When that word is the halt encoding, it freezes the program counter and the decode register. The halt stays parked in decode while the older instructions in execute, memory and writeback finish normally. A bubble goes into execute in place of the halt, so the halt itself never travels down the pipe.

While the pipeline is frozen, an 8-bit status word reports the stop and seven bits of the halt's code field. An external release level lets the parked halt go. The release passes through a one-shot circuit, so that one assertion frees exactly one halt. To free a later halt, release must drop and rise again. In the cycle the pulse fires, the holds drop and the halt leaves decode as a no-op. The status word reads zero again from the next cycle.

Top module: `halt_stall_ctrl`

## Requirements
- R1: A decode word is a halt only when the valid flag is 1, bits 31:26 (primary opcode) are 0, and bits 5:0 (function code) are 0x0D. Any other function code under opcode 0, or a halt pattern with valid 0, causes no hold, no bubble and no status change.
- R2: In every cycle a halt sits in decode and no release pulse is present, both `pc_hold` and `dec_hold` are 1 in that same cycle. They are 0 in every cycle in which no halt is in decode.
- R3: `ex_bubble` is 1 in every cycle a halt is in decode, including the cycle in which it is released, and 0 otherwise.
- R4: `status` is 0 whenever the pipeline is not stopped. From the cycle after a held halt is in decode, `status[7]` is 1 and `status[6:0]` equals instruction bits 12:6, which are the low seven bits of the code field in bits 25:6. The word stays stable while the hold lasts.
- R5: A release pulse fires only in the first cycle in which `release_in` is sampled high after having been low. While release stays high, no further pulse fires.
- R6: If a halt reaches decode while release is already high, that halt stays held. It is freed only after release goes low and then high again.
- R7: In the cycle of a release pulse with a halt in decode, `pc_hold` and `dec_hold` are 0. From the next cycle, `status` is 0.
- R8: During and right after reset, `status` is 0 and no hold is asserted. Reset treats release as previously low.
- R9: A release pulse that fires while no halt is in decode has no effect. A halt that arrives later is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_instr | input | 32 | Instruction word in the decode stage |
| dec_valid | input | 1 | Decode word is a real instruction |
| release_in | input | 1 | External release level |
| pc_hold | output | 1 | Stop the program counter this cycle |
| dec_hold | output | 1 | Keep the decode register this cycle |
| ex_bubble | output | 1 | Send a no-op into execute in place of the decode word |
| status | output | 8 | Stop flag (bit 7) and halt code bits (6:0), zero when running |

## Verification
The assertions assume the decode stage obeys `dec_hold`. While the hold is high, the same halt word with valid set is presented in the next cycle. The stimulus therefore re-presents the parked halt for as long as the expected hold is high, and moves on only after the release cycle.

The assertions also assume release is a level that is not toggled within a cycle. The stimulus changes release only at falling edges, and keeps it low across reset.

// File: rtl/halt_pkg.sv
package halt_pkg;
    localparam int INSTR_W    = 32;
    localparam int OPC_LSB    = 26;
    localparam int OPC_W      = 6;
    localparam int FUNCT_W    = 6;
    localparam int CODE_LSB   = 6;
    localparam int CODE_W     = 7;
    localparam int STAT_W     = CODE_W + 1;
    localparam logic [FUNCT_W-1:0] HALT_FUNCT = 6'h0D;

    typedef struct packed {
        logic              stopped;
        logic [CODE_W-1:0] code;
    } stop_state_t;
endpackage

// File: rtl/halt_detect.sv
module halt_detect
    import halt_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int FW = FUNCT_W,
    parameter logic [FUNCT_W-1:0] MATCH = HALT_FUNCT
) (
    input  logic          valid,
    input  logic [OW-1:0] opcode,
    input  logic [FW-1:0] funct,
    output logic          is_halt
);
    always_comb begin
        is_halt = valid && (opcode == '0) && (funct == MATCH);
    end
endmodule

// File: rtl/release_oneshot.sv
module release_oneshot (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = level;
        pulse  = level && !seen_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R5
    level_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> level);
endmodule

// File: rtl/halt_stall_ctrl.sv
module halt_stall_ctrl
    import halt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] dec_instr,
    input  logic               dec_valid,
    input  logic               release_in,
    output logic               pc_hold,
    output logic               dec_hold,
    output logic               ex_bubble,
    output logic [STAT_W-1:0]  status
);
    logic        halt_seen;
    logic        rel_pulse;
    logic        stall;
    stop_state_t st_d, st_q;
    logic        unused_bits;

    assign unused_bits = ^dec_instr[OPC_LSB-1:CODE_LSB+CODE_W];

    halt_detect u_det (
        .valid   (dec_valid),
        .opcode  (dec_instr[OPC_LSB +: OPC_W]),
        .funct   (dec_instr[FUNCT_W-1:0]),
        .is_halt (halt_seen)
    );

    release_oneshot u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .level (release_in),
        .pulse (rel_pulse)
    );

    always_comb begin
        stall      = halt_seen && !(st_q.stopped && rel_pulse);
        st_d       = st_q;
        st_d.stopped = stall;
        if (stall) st_d.code = dec_instr[CODE_LSB +: CODE_W];
        else       st_d.code = '0;
        pc_hold    = stall;
        dec_hold   = stall;
        ex_bubble  = halt_seen;
        status     = st_q.stopped ? {1'b1, st_q.code} : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    hold_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> ex_bubble);

    // R4
    hold_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> status[STAT_W-1]);

    // R4
    stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[STAT_W-1] |-> (status == '0));

    // R4
    stat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_W-1] && pc_hold) |=> $stable(status));

    // R7
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_W-1] && !pc_hold) |=> (status == '0));

    // R1
    no_halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_bubble |-> (!pc_hold && !dec_hold));
endmodule

// File: tb/sim_halt_stall_ctrl.sv
module sim_halt_stall_ctrl;
    import halt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dec_instr = '0;
    logic        dec_valid = 1'b0;
    logic        release_in = 1'b0;
    logic        pc_hold, dec_hold, ex_bubble;
    logic [7:0]  status;

    typedef struct {
        logic [10:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_run = 0;
    int n_fail = 0;
    logic       m_rel_prev = 1'b0;
    logic       m_stopped = 1'b0;
    logic [6:0] m_code = '0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    halt_stall_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .dec_instr(dec_instr), .dec_valid(dec_valid),
        .release_in(release_in), .pc_hold(pc_hold), .dec_hold(dec_hold),
        .ex_bubble(ex_bubble), .status(status)
    );

    function automatic logic [31:0] halt_word(input logic [19:0] code);
        return {6'd0, code, 6'h0D};
    endfunction

    task automatic step(input logic [31:0] w, input logic v, input logic r, input string tag);
        logic is_h, pulse, stall;
        item_t it;
        @(negedge clk);
        dec_instr  = w;
        dec_valid  = v;
        release_in = r;
        is_h  = v && (w[31:26] == 6'd0) && (w[5:0] == 6'h0D);
        pulse = r && !m_rel_prev;
        stall = is_h && !(m_stopped && pulse);
        it.exp = {stall, stall, is_h, (m_stopped ? {1'b1, m_code} : 8'd0)};
        it.tag = tag;
        sb.push_back(it);
        m_stopped  = stall;
        m_code     = w[12:6];
        m_rel_prev = r;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                logic [10:0] act;
                it  = sb.pop_front();
                act = {pc_hold, dec_hold, ex_bubble, status};
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        #1;
        n_run++;
        if ({pc_hold, dec_hold, status} !== 10'd0) begin
            n_fail++;
            $display("FAIL R8: actual %h expected 0", {pc_hold, dec_hold, status});
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R8: idle right after reset
        step(32'h0, 1'b0, 1'b0, "R8");
        // R1: ordinary words, other function code, invalid halt
        step(32'h0123_4567, 1'b1, 1'b0, "R1");
        step({6'd0, 20'h00055, 6'h0C}, 1'b1, 1'b0, "R1");
        step(halt_word(20'h00011), 1'b0, 1'b0, "R1");
        step({6'd4, 20'h00011, 6'h0D}, 1'b1, 1'b0, "R1");
        // R2 R4: halt held, code has upper bits set to check masking
        for (int i = 0; i < 5; i++) step(halt_word(20'hABC2A), 1'b1, 1'b0, "R2_R4");
        // R7 R3: release pulse frees halt
        step(halt_word(20'hABC2A), 1'b1, 1'b1, "R7_R3");
        step(32'h1111_1111, 1'b1, 1'b1, "R7");
        step(32'h2222_2222, 1'b1, 1'b1, "R5");
        // R6: release already high when new halt arrives
        for (int i = 0; i < 4; i++) step(halt_word(20'h0007F), 1'b1, 1'b1, "R6");
        step(halt_word(20'h0007F), 1'b1, 1'b0, "R6");
        step(halt_word(20'h0007F), 1'b1, 1'b0, "R6");
        step(halt_word(20'h0007F), 1'b1, 1'b1, "R6_R7");
        step(32'h0, 1'b1, 1'b1, "R7");
        step(32'h0, 1'b1, 1'b0, "R5");
        // R9: pulse with no halt in decode, then a halt is still held
        step(32'h3333_3333, 1'b1, 1'b1, "R9");
        step(halt_word(20'h00005), 1'b1, 1'b1, "R9");
        for (int i = 0; i < 3; i++) step(halt_word(20'h00005), 1'b1, 1'b1, "R9");
        step(halt_word(20'h00005), 1'b1, 1'b0, "R5");
        step(halt_word(20'h00005), 1'b1, 1'b1, "R7");
        step(32'h0, 1'b0, 1'b0, "R7");
        // R2: back-to-back halts, each needs its own release
        step(halt_word(20'h00001), 1'b1, 1'b0, "R2");
        step(halt_word(20'h00001), 1'b1, 1'b1, "R2_R7");
        step(halt_word(20'h00002), 1'b1, 1'b1, "R5_R2");
        step(halt_word(20'h00002), 1'b1, 1'b0, "R2");
        step(halt_word(20'h00002), 1'b1, 1'b1, "R7");
        step(32'h0, 1'b0, 1'b0, "R4");
        step(32'h0, 1'b0, 1'b0, "R4");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule